// File: doc/BRIEF.md
# Compare-Match Timer with PWM Mode

This block is a small counter peripheral with two modes, picked by a control bit. In interval mode an up-counter runs until it equals a compare value. On that cycle the counter returns to zero, a sticky match flag is set, an optional interrupt pulse is raised and a toggle output inverts. In PWM mode the counter runs freely over a fixed period of 2^CNT_W counts, and the compare value sets how many counts of each period the output stays high.

Software reaches the block through a byte-wide register bus with two locations: a control/status byte at offset 0 and the compare byte at offset 1. The match flag is cleared by writing 0 to its bit, and a written 1 leaves it alone. A strobe marks the read phase of a read-modify-write access. During that phase the flag reads as 1, so the write-back that follows cannot clear it by accident.

An output mux hands the pin either to the timer or to a general-purpose port value. When the timer owns the pin, its driver is forced on whatever the port direction says.

Top module: `cmt_pwm_timer`

## Requirements
- R1: After reset the control byte reads 0x00, and `pin_out`, `pin_oe` and `irq` are all 0.
- R2: Interval mode (control bit 3 = 0, bit 4 run = 1). The counter counts up from 0 and returns to 0 on the cycle after it equals the compare value. The toggle output inverts once per match, so `pin_out` changes every cmp+1 cycles.
- R3: In interval mode the match flag (control bit 2) becomes 1 after a match.
- R4: A control write with bit 2 = 0 clears the match flag. A control write with bit 2 = 1 leaves the flag unchanged. A match in the same cycle wins over a clear.
- R5: A control read with `bus_rmw` = 1 returns bit 2 as 1 in interval mode, whatever the stored flag holds.
- R6: With interrupt enable (control bit 0) set in interval mode, `irq` gives a one-cycle pulse per match. With the bit clear, `irq` stays 0.
- R7: In PWM mode (control bit 3 = 1) the period is 2^CNT_W cycles, and `pin_out` is high for exactly cmp cycles of each period. A compare value of 0 keeps the output low.
- R8: In PWM mode `irq` stays 0 and the flag bit reads 0. Writes to the flag bit are ignored, and the stored flag is visible again after a return to interval mode.
- R9: With output enable (control bit 1) = 1, `pin_oe` is 1 and `pin_out` carries the timer output, even when `gpio_dir` is 0. With output enable = 0, `pin_oe` follows `gpio_dir` and `pin_out` follows `gpio_val`.
- R10: With run (control bit 4) = 0, the counter is held at 0 and the toggle output is driven low. After run is set, the first toggle reaches the pin 7 cycles after the write edge when cmp = 5.
- R11: The compare register is write-only, and reads at offset 1 return 0x00.
- R12: Reads are registered, so `bus_rdata` is valid in the cycle after an access with `bus_sel` = 1 and `bus_wr` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = control/status byte, 1 = compare byte |
| bus_wdata | input | 8 | Write data |
| bus_rmw | input | 1 | Marks the read phase of a read-modify-write access |
| bus_rdata | output | 8 | Registered read data |
| gpio_val | input | 1 | General-purpose port output value |
| gpio_dir | input | 1 | General-purpose port direction, 1 = output |
| pin_out | output | 1 | Pin data, registered |
| pin_oe | output | 1 | Pin driver enable, registered |
| irq | output | 1 | Match interrupt pulse |

## Verification
Some properties are checked by assertions on every cycle:
- the counter returns to zero after each interval match;
- a stopped counter stays at zero with its toggle output low;
- the flag is set after a match, and it stays frozen while the block is in PWM mode;
- a read-modify-write read of the control byte returns the flag bit as 1;
- PWM mode never raises an interrupt;
- the output enable forces the pin driver on.

Other behaviour can only be shown by the bench scenarios: the exact toggle interval and the latency from a restart, the per-period duty count for several compare values, the interrupt pulse count, and the flag surviving writes made in PWM mode.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  localparam int BUS_W = 8;

  localparam int B_IEN  = 0;
  localparam int B_OE   = 1;
  localparam int B_FLAG = 2;
  localparam int B_PWM  = 3;
  localparam int B_RUN  = 4;

  localparam logic A_CTRL = 1'b0;
  localparam logic A_CMP  = 1'b1;

  typedef struct packed {
    logic run;
    logic pwm;
    logic flag;
    logic oe;
    logic ien;
  } ctrl_t;
endpackage

// File: rtl/cmt_regs.sv
module cmt_regs
  import cmt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sel,
  input  logic                  wr,
  input  logic                  addr,
  input  logic [BUS_W-1:0]      wdata,
  input  logic                  rmw,
  input  logic                  match,
  output ctrl_t                 ctrl,
  output logic [CNT_W-1:0]      cmp,
  output logic [BUS_W-1:0]      rdata
);
  localparam int PAD_W = BUS_W - CNT_W;

  logic             wr_ctrl, wr_cmp, rd_any;
  logic [BUS_W-1:0] rd_mux;
  logic             unused_wbits;

  assign wr_ctrl = sel && wr && (addr == A_CTRL);
  assign wr_cmp  = sel && wr && (addr == A_CMP);
  assign rd_any  = sel && !wr;
  assign unused_wbits = ^wdata;

  always_comb begin
    rd_mux = '0;
    if (addr == A_CTRL) begin
      rd_mux[B_IEN]  = ctrl.ien;
      rd_mux[B_OE]   = ctrl.oe;
      rd_mux[B_PWM]  = ctrl.pwm;
      rd_mux[B_RUN]  = ctrl.run;
      rd_mux[B_FLAG] = ctrl.pwm ? 1'b0 : (rmw ? 1'b1 : ctrl.flag);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl  <= '0;
      cmp   <= '0;
      rdata <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl.ien <= wdata[B_IEN];
        ctrl.oe  <= wdata[B_OE];
        ctrl.pwm <= wdata[B_PWM];
        ctrl.run <= wdata[B_RUN];
      end
      if (!ctrl.pwm) begin
        if (match)
          ctrl.flag <= 1'b1;
        else if (wr_ctrl && !wdata[B_FLAG])
          ctrl.flag <= 1'b0;
      end
      if (wr_cmp)
        cmp <= wdata[CNT_W-1:0];
      if (rd_any)
        rdata <= rd_mux;
    end
  end

  initial begin
    if (PAD_W < 0) $error("CNT_W must not exceed the bus width");
  end

  assert_flag_set_R3: assert property (@(posedge clk) disable iff (rst)
    match |=> ctrl.flag);

  assert_pwm_flag_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    ctrl.pwm |=> $stable(ctrl.flag));

  assert_rmw_flag_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_any && rmw && (addr == A_CTRL) && !ctrl.pwm) |=> rdata[B_FLAG]);
endmodule

// File: rtl/cmt_core.sv
module cmt_core #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             pwm,
  input  logic             ien,
  input  logic [CNT_W-1:0] cmp,
  output logic             match,
  output logic             tmr_out,
  output logic             irq
);
  logic [CNT_W-1:0] cnt;
  logic             tgl;
  logic             pwm_q;

  assign match   = run && !pwm && (cnt == cmp);
  assign tmr_out = pwm ? pwm_q : tgl;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      tgl   <= 1'b0;
      pwm_q <= 1'b0;
      irq   <= 1'b0;
    end else begin
      irq <= match && ien;
      if (!run) begin
        cnt   <= '0;
        tgl   <= 1'b0;
        pwm_q <= 1'b0;
      end else if (pwm) begin
        cnt   <= cnt + 1'b1;
        pwm_q <= (cnt < cmp);
      end else if (match) begin
        cnt <= '0;
        tgl <= ~tgl;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assert_clear_on_match_R2: assert property (@(posedge clk) disable iff (rst)
    match |=> (cnt == '0));

  assert_hold_stopped_R10: assert property (@(posedge clk) disable iff (rst)
    !run |=> ((cnt == '0) && !tgl));

  assert_pwm_no_irq_R8: assert property (@(posedge clk) disable iff (rst)
    pwm |=> !irq);
endmodule

// File: rtl/cmt_pin.sv
module cmt_pin (
  input  logic clk,
  input  logic rst,
  input  logic oe,
  input  logic tmr_out,
  input  logic gpio_val,
  input  logic gpio_dir,
  output logic pin_out,
  output logic pin_oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pin_out <= 1'b0;
      pin_oe  <= 1'b0;
    end else begin
      pin_out <= oe ? tmr_out : gpio_val;
      pin_oe  <= oe | gpio_dir;
    end
  end

  assert_oe_override_R9: assert property (@(posedge clk) disable iff (rst)
    oe |=> pin_oe);

  assert_gpio_pass_R9: assert property (@(posedge clk) disable iff (rst)
    !oe |=> (pin_out == $past(gpio_val)));
endmodule

// File: rtl/cmt_pwm_timer.sv
module cmt_pwm_timer
  import cmt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic             bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  input  logic             bus_rmw,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic             gpio_val,
  input  logic             gpio_dir,
  output logic             pin_out,
  output logic             pin_oe,
  output logic             irq
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] cmp;
  logic             match;
  logic             tmr_out;

  cmt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .rmw(bus_rmw), .match(match),
    .ctrl(ctrl), .cmp(cmp), .rdata(bus_rdata)
  );

  cmt_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .run(ctrl.run), .pwm(ctrl.pwm), .ien(ctrl.ien),
    .cmp(cmp), .match(match), .tmr_out(tmr_out), .irq(irq)
  );

  cmt_pin u_pin (
    .clk(clk), .rst(rst), .oe(ctrl.oe), .tmr_out(tmr_out),
    .gpio_val(gpio_val), .gpio_dir(gpio_dir),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );
endmodule

// File: tb/sim_cmt_pwm_timer.sv
module sim_cmt_pwm_timer;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sel = 1'b0, wr = 1'b0, addr = 1'b0, rmw = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       gpio_val = 1'b0, gpio_dir = 1'b0;
  logic       pin_out, pin_oe, irq;

  int  n_chk = 0, n_fail = 0, cyc = 0;
  bit  done = 1'b0;
  logic rd_seen = 1'b0;

  logic [7:0] exp_q[$];
  string      req_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cmt_pwm_timer u0 (
    .clk(clk), .rst(rst), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rmw(rmw), .bus_rdata(rdata),
    .gpio_val(gpio_val), .gpio_dir(gpio_dir),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  always @(posedge clk) begin
    cyc     <= cyc + 1;
    rd_seen <= sel && !wr;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: compares registered read data against the scoreboard queue
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [7:0] e;
      string r;
      e = exp_q.pop_front();
      r = req_q.pop_front();
      chk(r, rdata, e);
    end
  end

  task automatic bus_write(input logic a, input logic [7:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_read(input logic a, input logic m, input logic [7:0] e, input string r);
    @(negedge clk);
    sel = 1'b1; wr = 1'b0; addr = a; rmw = m;
    exp_q.push_back(e);
    req_q.push_back(r);
    @(negedge clk);
    sel = 1'b0; rmw = 1'b0;
  endtask

  task automatic count_win(input int n, output int hi, output int irqs);
    hi = 0; irqs = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      hi   += int'(pin_out);
      irqs += int'(irq);
    end
  endtask

  task automatic wait_pin_change(output int dt);
    logic p;
    int   c0;
    p = pin_out; c0 = cyc; dt = -1;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (pin_out != p) begin
        dt = cyc - c0;
        break;
      end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    int dt, hi, irqs;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 pin_out", pin_out, 0);
    chk("R1 pin_oe", pin_oe, 0);
    chk("R1 irq", irq, 0);
    bus_read(1'b0, 1'b0, 8'h00, "R1 R12 ctrl reset");

    // R9 general-purpose path
    gpio_dir = 1'b1; gpio_val = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 gpio pin_oe", pin_oe, 1);
    chk("R9 gpio pin_out", pin_out, 1);
    gpio_dir = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 gpio dir in", pin_oe, 0);

    // R9 override with output enable, counter stopped (R10 low)
    bus_write(1'b0, 8'h02);
    @(negedge clk);
    chk("R9 oe override pin_oe", pin_oe, 1);
    chk("R10 stopped pin low", pin_out, 0);

    // R2 R6 interval mode cmp=5
    bus_write(1'b1, 8'd5);
    bus_write(1'b0, 8'h13);
    wait_pin_change(dt);
    chk("R10 first toggle latency", dt, 7);
    for (int k = 0; k < 3; k++) begin
      wait_pin_change(dt);
      chk("R2 toggle interval", dt, 6);
    end
    count_win(60, hi, irqs);
    chk("R6 irq pulses", irqs, 10);
    bus_read(1'b0, 1'b0, 8'h17, "R3 flag set");
    bus_read(1'b1, 1'b0, 8'h00, "R11 compare write-only");

    // R6 interrupt disabled, R4 writing 1 keeps flag
    bus_write(1'b0, 8'h16);
    count_win(60, hi, irqs);
    chk("R6 irq disabled", irqs, 0);
    bus_read(1'b0, 1'b0, 8'h16, "R4 write 1 keeps");

    // R10 stop, R4 clear, R5 rmw
    bus_write(1'b0, 8'h06);
    repeat (2) @(negedge clk);
    chk("R10 stop drives low", pin_out, 0);
    bus_read(1'b0, 1'b0, 8'h06, "R4 flag kept while stopped");
    bus_write(1'b0, 8'h02);
    bus_read(1'b0, 1'b0, 8'h02, "R4 write 0 clears");
    bus_read(1'b0, 1'b1, 8'h06, "R5 rmw reads flag 1");

    // set the flag again, then enter PWM mode
    bus_write(1'b0, 8'h12);
    repeat (20) @(negedge clk);
    bus_write(1'b1, 8'd64);
    bus_write(1'b0, 8'h1F);
    bus_read(1'b0, 1'b0, 8'h1B, "R8 flag reads 0 in pwm");
    repeat (300) @(negedge clk);
    count_win(256, hi, irqs);
    chk("R7 duty 64", hi, 64);
    chk("R8 no irq in pwm", irqs, 0);
    bus_write(1'b0, 8'h1B);
    bus_write(1'b1, 8'd0);
    repeat (300) @(negedge clk);
    count_win(256, hi, irqs);
    chk("R7 duty 0", hi, 0);
    bus_write(1'b1, 8'd255);
    repeat (300) @(negedge clk);
    count_win(256, hi, irqs);
    chk("R7 duty 255", hi, 255);
    chk("R8 no irq in pwm 255", irqs, 0);
    bus_write(1'b1, 8'd1);
    repeat (300) @(negedge clk);
    count_win(512, hi, irqs);
    chk("R7 duty 1 over two periods", hi, 2);

    // R8 flag survived the pwm-mode write of 0
    bus_write(1'b0, 8'h06);
    bus_read(1'b0, 1'b0, 8'h06, "R8 flag preserved");

    repeat (4) @(negedge clk);
    chk("R12 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule